// File: doc/BRIEF.md
# Embedded-Algorithm Completion Poller

This block takes over once a sequencer has issued a program or erase command to a parallel flash device. It repeatedly reads status from one address inside the operation and decides from those reads alone whether the device's internal algorithm has finished. To do this it generates its own chip-select and output-enable read cycles with cycle-counted address setup and access time.

Each new read is compared with the previous one. A status bit that flips on every read means the device is still working. A second bit that flips only inside a sector whose erase is suspended identifies that case. The top status bit carries complemented data while a program runs and zero while an erase runs, so it confirms the final value. The ready pin is sampled together with each status read. A per-operation watchdog, loaded from the worst-case program or erase time, ends a poll that never settles.

The sequencer sees a busy flag and then a one-cycle result pulse carrying one of four codes.

Top module: `status_poller`

## Requirements
- R1: While reset is held and after its release until a start, busy_o and result_valid_o are 0 and flash_cs_n_o and flash_oe_n_o are 1.
- R2: When start_i is 1 while busy_o is 0, busy_o is 1 from the next cycle and flash_addr_o carries the poll address captured at that edge until the result. A start_i pulse while busy_o is 1 has no effect on the address, the read cycles or the result.
- R3: Every status read holds flash_cs_n_o low with flash_oe_n_o high for SETUP_CYC cycles, then both low for ACCESS_CYC cycles, and samples the status at the edge that ends the last access cycle. flash_cs_n_o and flash_oe_n_o are then both high for GAP_CYC cycles before the next read.
- R4: flash_sts_i carries DQ7 in bit 3, DQ6 in bit 2, DQ5 in bit 1 and DQ2 in bit 0. The first read of an operation only records status. When DQ6 differs from the previous read and DQ5 has not already been seen high on a toggling read, polling continues.
- R5: When DQ6 and DQ2 both equal the previous read, DQ7 equals the expected value and flash_rdy_i is 1, the result code is 0 (done). The expected DQ7 is prog_d7_i for a program and 1 for an erase (erase_i = 1 at start).
- R6: When DQ6 and DQ2 are unchanged but DQ7 differs from the expected value or flash_rdy_i is 0, polling continues.
- R7: When DQ6 is unchanged and DQ2 differs from the previous read, the result code is 1 (sector erase-suspended).
- R8: A toggling read with DQ5 = 1 marks the operation. If DQ6 toggles again on any later read, the result code is 2 (device error). Otherwise later reads are judged as in R5 to R7.
- R9: If no result has been decided at the PROG_LIMIT-th clock edge after the start edge (ERASE_LIMIT-th for an erase), the result code is 3 (timeout). A status decision at that same edge takes priority.
- R10: result_valid_o is 1 for exactly one cycle, the cycle in which busy_o has just fallen. In that cycle flash_cs_n_o and flash_oe_n_o are 1 and result_code_o holds the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin polling (accepted only while idle) |
| erase_i | input | 1 | 1: erase operation, 0: program operation |
| poll_addr_i | input | AW | Address inside the operation to read status from |
| prog_d7_i | input | 1 | Bit 7 of the word being programmed |
| flash_sts_i | input | 4 | Status lanes {DQ7, DQ6, DQ5, DQ2} from the device |
| flash_rdy_i | input | 1 | Device ready pin, 1 = ready |
| flash_addr_o | output | AW | Address driven to the device |
| flash_cs_n_o | output | 1 | Chip select, active low |
| flash_oe_n_o | output | 1 | Output enable, active low |
| busy_o | output | 1 | Polling in progress |
| result_valid_o | output | 1 | One-cycle result strobe |
| result_code_o | output | 2 | 0 done, 1 suspended, 2 device error, 3 timeout |

## Verification
A stale previous-status record or a lost DQ5 mark shows at the ports as a result code from the wrong class, or as a result strobe that comes a whole read period (SETUP_CYC + ACCESS_CYC + GAP_CYC cycles) early or late. A phase counter off by one shows within the first read as chip-select or output-enable edges one cycle out of place. A watchdog loaded with the wrong limit moves the timeout strobe away from the exact edge count. The bench predicts every control output on every cycle from a period-and-offset model and the decisive read from the queued status sequence, so each of these faults is seen on the first cycle where it differs.

// File: rtl/poll_pkg.sv
package poll_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2,
        PH_GAP    = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        RES_DONE    = 2'd0,
        RES_SUSP    = 2'd1,
        RES_FAIL    = 2'd2,
        RES_TIMEOUT = 2'd3
    } result_e;

    typedef enum logic [1:0] {
        V_CONT = 2'd0,
        V_DONE = 2'd1,
        V_SUSP = 2'd2,
        V_FAIL = 2'd3
    } verdict_e;

    // status lanes as wired at the port: {DQ7, DQ6, DQ5, DQ2}
    typedef struct packed {
        logic d7;
        logic d6;
        logic d5;
        logic d2;
    } sts_t;

endpackage

// File: rtl/poll_judge.sv
module poll_judge
    import poll_pkg::*;
(
    input  sts_t     prev_i,
    input  sts_t     cur_i,
    input  logic     want_d7_i,
    input  logic     rdy_i,
    input  logic     dq5_seen_i,
    output verdict_e verdict_o,
    output logic     dq5_mark_o
);

    logic flip6;
    logic flip2;

    assign flip6 = prev_i.d6 ^ cur_i.d6;
    assign flip2 = prev_i.d2 ^ cur_i.d2;

    always_comb begin
        dq5_mark_o = flip6 & cur_i.d5;
        if (flip6) begin
            verdict_o = dq5_seen_i ? V_FAIL : V_CONT;
        end else if (flip2) begin
            verdict_o = V_SUSP;
        end else if ((cur_i.d7 == want_d7_i) && rdy_i) begin
            verdict_o = V_DONE;
        end else begin
            verdict_o = V_CONT;
        end
    end

endmodule

// File: rtl/poll_watchdog.sv
module poll_watchdog #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         run_i,
    input  logic [W-1:0] limit_i,
    output logic         expire_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = limit_i;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expire_o = run_i && (cnt_q == W'(1));

endmodule

// File: rtl/status_poller.sv
module status_poller
    import poll_pkg::*;
#(
    parameter int          AW          = 21,
    parameter int          SETUP_CYC   = 2,
    parameter int          ACCESS_CYC  = 9,
    parameter int          GAP_CYC     = 1,
    parameter int unsigned PROG_LIMIT  = 30000,
    parameter int unsigned ERASE_LIMIT = 500000000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          erase_i,
    input  logic [AW-1:0] poll_addr_i,
    input  logic          prog_d7_i,
    input  logic [3:0]    flash_sts_i,
    input  logic          flash_rdy_i,
    output logic [AW-1:0] flash_addr_o,
    output logic          flash_cs_n_o,
    output logic          flash_oe_n_o,
    output logic          busy_o,
    output logic          result_valid_o,
    output logic [1:0]    result_code_o
);

    localparam int          M1      = (SETUP_CYC > ACCESS_CYC) ? SETUP_CYC : ACCESS_CYC;
    localparam int          M2      = (M1 > GAP_CYC) ? M1 : GAP_CYC;
    localparam int          CW      = $clog2(M2) + 1;
    localparam int unsigned LIM_MAX = (ERASE_LIMIT > PROG_LIMIT) ? ERASE_LIMIT : PROG_LIMIT;
    localparam int          WD_W    = $clog2(LIM_MAX + 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic          want_d7;
        sts_t          prev;
        logic          have_prev;
        logic          dq5_seen;
        logic          res_valid;
        logic [1:0]    res_code;
    } ctl_t;

    ctl_t c_d, c_q;

    sts_t           cur_sts;
    verdict_e       verdict;
    logic           dq5_mark;
    logic           wd_load;
    logic           wd_run;
    logic           wd_expire;
    logic [WD_W-1:0] wd_limit;

    assign cur_sts  = sts_t'(flash_sts_i);
    assign wd_load  = (c_q.ph == PH_IDLE) && start_i;
    assign wd_run   = (c_q.ph != PH_IDLE);
    assign wd_limit = erase_i ? WD_W'(ERASE_LIMIT) : WD_W'(PROG_LIMIT);

    poll_judge u_judge (
        .prev_i     (c_q.prev),
        .cur_i      (cur_sts),
        .want_d7_i  (c_q.want_d7),
        .rdy_i      (flash_rdy_i),
        .dq5_seen_i (c_q.dq5_seen),
        .verdict_o  (verdict),
        .dq5_mark_o (dq5_mark)
    );

    poll_watchdog #(.W(WD_W)) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (wd_load),
        .run_i    (wd_run),
        .limit_i  (wd_limit),
        .expire_o (wd_expire)
    );

    always_comb begin
        logic decided;
        c_d           = c_q;
        c_d.res_valid = 1'b0;
        decided       = 1'b0;
        unique case (c_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    c_d.ph        = PH_SETUP;
                    c_d.cnt       = CW'(SETUP_CYC - 1);
                    c_d.addr      = poll_addr_i;
                    c_d.want_d7   = erase_i ? 1'b1 : prog_d7_i;
                    c_d.have_prev = 1'b0;
                    c_d.dq5_seen  = 1'b0;
                end
            end
            PH_SETUP: begin
                if (c_q.cnt == '0) begin
                    c_d.ph  = PH_ACCESS;
                    c_d.cnt = CW'(ACCESS_CYC - 1);
                end else begin
                    c_d.cnt = c_q.cnt - CW'(1);
                end
            end
            PH_ACCESS: begin
                if (c_q.cnt == '0) begin
                    if (c_q.have_prev && (verdict != V_CONT)) begin
                        decided       = 1'b1;
                        c_d.ph        = PH_IDLE;
                        c_d.res_valid = 1'b1;
                        unique case (verdict)
                            V_DONE:  c_d.res_code = RES_DONE;
                            V_SUSP:  c_d.res_code = RES_SUSP;
                            default: c_d.res_code = RES_FAIL;
                        endcase
                    end else begin
                        c_d.ph        = PH_GAP;
                        c_d.cnt       = CW'(GAP_CYC - 1);
                        c_d.prev      = cur_sts;
                        c_d.have_prev = 1'b1;
                        c_d.dq5_seen  = c_q.dq5_seen | (c_q.have_prev & dq5_mark);
                    end
                end else begin
                    c_d.cnt = c_q.cnt - CW'(1);
                end
            end
            PH_GAP: begin
                if (c_q.cnt == '0) begin
                    c_d.ph  = PH_SETUP;
                    c_d.cnt = CW'(SETUP_CYC - 1);
                end else begin
                    c_d.cnt = c_q.cnt - CW'(1);
                end
            end
            default: c_d.ph = PH_IDLE;
        endcase
        if (wd_run && wd_expire && !decided) begin
            c_d.ph        = PH_IDLE;
            c_d.res_valid = 1'b1;
            c_d.res_code  = RES_TIMEOUT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign flash_addr_o   = c_q.addr;
    assign flash_cs_n_o   = !((c_q.ph == PH_SETUP) || (c_q.ph == PH_ACCESS));
    assign flash_oe_n_o   = !(c_q.ph == PH_ACCESS);
    assign busy_o         = (c_q.ph != PH_IDLE);
    assign result_valid_o = c_q.res_valid;
    assign result_code_o  = c_q.res_code;

endmodule

// File: rtl/status_poller_chk.sv
module status_poller_chk #(
    parameter int AW = 21
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [AW-1:0] flash_addr_o,
    input logic          flash_cs_n_o,
    input logic          flash_oe_n_o,
    input logic          busy_o,
    input logic          result_valid_o
);

    p_oe_inside_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_oe_n_o |-> !flash_cs_n_o);

    p_setup_before_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flash_oe_n_o) |-> $past(!flash_cs_n_o));

    p_start_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(flash_addr_o));

    p_result_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid_o |=> !result_valid_o);

    p_result_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid_o |-> (!busy_o && flash_cs_n_o && flash_oe_n_o));

    p_busy_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> result_valid_o);

endmodule

bind status_poller status_poller_chk #(.AW(AW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .flash_addr_o   (flash_addr_o),
    .flash_cs_n_o   (flash_cs_n_o),
    .flash_oe_n_o   (flash_oe_n_o),
    .busy_o         (busy_o),
    .result_valid_o (result_valid_o)
);

// File: tb/status_poller_test.sv
module status_poller_test;

    localparam int S  = 2;
    localparam int A  = 9;
    localparam int G  = 1;
    localparam int P  = S + A + G;
    localparam int PL = 395;
    localparam int EL = 300;
    localparam int AW = 21;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          erase = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic          pd7 = 1'b0;
    logic [3:0]    sts = 4'b0;
    logic          rdy = 1'b0;
    logic [AW-1:0] f_addr;
    logic          cs_n, oe_n, busy, rv;
    logic [1:0]    code;

    int checks = 0;
    int fails  = 0;

    logic [3:0] rq_sts[$];
    logic       rq_rdy[$];
    logic       oe_was = 1'b1;

    always #5 clk = ~clk;

    status_poller #(
        .AW(AW), .SETUP_CYC(S), .ACCESS_CYC(A), .GAP_CYC(G),
        .PROG_LIMIT(PL), .ERASE_LIMIT(EL)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .erase_i(erase),
        .poll_addr_i(paddr), .prog_d7_i(pd7), .flash_sts_i(sts),
        .flash_rdy_i(rdy), .flash_addr_o(f_addr), .flash_cs_n_o(cs_n),
        .flash_oe_n_o(oe_n), .busy_o(busy), .result_valid_o(rv),
        .result_code_o(code)
    );

    // device stand-in: each new output-enable low period delivers the next status
    always @(negedge clk) begin
        if (!oe_n && oe_was && rq_sts.size() > 0) begin
            sts <= rq_sts.pop_front();
            rdy <= rq_rdy.pop_front();
        end
        oe_was <= oe_n;
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic [3:0] s, input logic r);
        rq_sts.push_back(s);
        rq_rdy.push_back(r);
    endtask

    // bits: [3]=DQ7 [2]=DQ6 [1]=DQ5 [0]=DQ2
    task automatic predict(input logic want7, input int lim,
                           output int end_c, output int res);
        bit mark = 0;
        end_c = lim;
        res   = 3;
        for (int i = 1; i < rq_sts.size(); i++) begin
            int c = (i + 1) * P - G;
            bit t6, t2;
            if (c > lim) break;
            t6 = rq_sts[i][2] ^ rq_sts[i-1][2];
            t2 = rq_sts[i][0] ^ rq_sts[i-1][0];
            if (t6) begin
                if (mark) begin end_c = c; res = 2; return; end
                if (rq_sts[i][1]) mark = 1;
            end else if (t2) begin
                end_c = c; res = 1; return;
            end else if (rq_sts[i][3] == want7 && rq_rdy[i]) begin
                end_c = c; res = 0; return;
            end
        end
    endtask

    task automatic run_op(input bit er, input logic [AW-1:0] a, input logic d7,
                          input string tag, input int intr_c);
        int end_c, res, c;
        predict(er ? 1'b1 : d7, er ? EL : PL, end_c, res);
        @(negedge clk);
        erase = er; paddr = a; pd7 = d7; start = 1'b1;
        c = 0;
        while (1) begin
            @(negedge clk);
            if (c < end_c) begin
                int r = c % P;
                chk(busy === 1'b1, "R2", "busy", busy, 1);
                chk(f_addr === a, "R2", "addr", f_addr, a);
                chk(cs_n === (r >= S + A), "R3", "cs_n", cs_n, (r >= S + A));
                chk(oe_n === !(r >= S && r < S + A), "R3", "oe_n", oe_n,
                    !(r >= S && r < S + A));
                chk(rv === 1'b0, "R10", "early result", rv, 0);
            end else begin
                chk(rv === 1'b1, tag, "result strobe", rv, 1);
                chk(busy === 1'b0, "R10", "busy at result", busy, 0);
                chk(cs_n === 1'b1 && oe_n === 1'b1, "R10", "bus idle at result",
                    {cs_n, oe_n}, 3);
                chk(code === res[1:0], tag, "result code", code, res);
                start = 1'b0;
                break;
            end
            if (intr_c > 0 && c == intr_c) begin
                start = 1'b1; paddr = ~a;   // R2: must be ignored while busy
            end else begin
                start = 1'b0; paddr = a;
            end
            c++;
        end
        @(negedge clk);
        chk(rv === 1'b0, "R10", "strobe length", rv, 0);
        rq_sts.delete();
        rq_rdy.delete();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy === 0 && rv === 0 && cs_n === 1 && oe_n === 1, "R1",
            "in reset", {busy, rv, cs_n, oe_n}, 3);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(busy === 0 && rv === 0 && cs_n === 1 && oe_n === 1, "R1",
            "after reset", {busy, rv, cs_n, oe_n}, 3);

        // R5 program done after one toggle, with an ignored start (R2)
        push(4'b0000, 0); push(4'b0100, 0); push(4'b1100, 1);
        run_op(0, 21'h0ABCD, 1'b1, "R5", 5);

        // R6 stable DQ6 but DQ7 wrong, then not ready, then done
        push(4'b1000, 0); push(4'b1000, 0); push(4'b0000, 0); push(4'b0000, 1);
        run_op(0, 21'h1F001, 1'b0, "R6", 0);

        // R4 R5 erase: DQ7 0 while toggling, then 1
        push(4'b0000, 0); push(4'b0100, 0); push(4'b0000, 0); push(4'b1000, 1);
        run_op(1, 21'h12345, 1'b0, "R4", 0);

        // R7 DQ2 flips with DQ6 stable
        push(4'b0100, 1); push(4'b0101, 1);
        run_op(1, 21'h00777, 1'b0, "R7", 0);

        // R8 DQ5 on a toggling read, then toggling again
        push(4'b0000, 0); push(4'b0100, 0); push(4'b0010, 0); push(4'b0110, 0);
        run_op(0, 21'h0F0F0, 1'b1, "R8", 0);

        // R8 DQ5 on a toggling read, then settled
        push(4'b0000, 0); push(4'b0110, 0); push(4'b1110, 1);
        run_op(0, 21'h0F0F1, 1'b1, "R8", 0);

        // R9 program never settles
        for (int k = 0; k < 40; k++) push({1'b0, k[0], 2'b00}, 0);
        run_op(0, 21'h00042, 1'b1, "R9", 0);

        // R9 decision on the same edge as expiry wins
        for (int k = 0; k < 32; k++) push({1'b0, k[0], 2'b00}, 0);
        push(4'b1100, 1);
        run_op(0, 21'h00043, 1'b1, "R9", 0);

        // R9 erase limit
        for (int k = 0; k < 30; k++) push({1'b0, k[0], 2'b00}, 0);
        run_op(1, 21'h1AAAA, 1'b0, "R9", 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule